// File: doc/BRIEF.md
# HDLC Serial Frame Transmitter

This block turns a byte stream from attached terminal equipment into a bit-serial HDLC line signal. While no message is pending it repeats the flag octet. When the equipment raises the message-enable input, each byte it presents is taken on a byte-request strobe that the block generates. The byte is shifted out least significant bit first, and a zero is inserted after any run of five ones. The equipment ends the frame by raising the FCS command for one byte period per trailer byte. The block then sends the complemented CRC, 16 or 32 bits wide as a configuration input selects, followed by a closing flag.

A bit-enable input paces the line. Each enabled clock cycle emits one line bit, either a payload bit or a stuffed zero. Stuffed zeros stretch the byte timing, so the byte request is tied to the cycle that emits the last bit of the current octet. The controller has three named states. IDLE sends flags and moves to DATA (transition *open*) when a byte request sees message-enable high and the FCS command low. DATA moves to FCS (transition *trail*) when a byte request sees the FCS command. DATA returns to IDLE (transition *abandon*) when a byte request sees message-enable low. FCS returns to IDLE (transition *close*) after the last trailer byte. A global enable and a loopback tap complete the interface.

Top module: `hdlc_tx_serializer`

## Requirements
- R1: With message-enable low, the line carries back-to-back flag octets 0x7E. Each flag goes out LSB first as the bit sequence 0,1,1,1,1,1,1,0, and flags are never bit-stuffed.
- R2: `byte_req` is high for exactly one cycle, and only in a cycle with `bit_en` high. That cycle is the one in which the last bit of the current octet is emitted. `tx_data`, `msg_en` and `fcs_cmd` are sampled in that cycle. A run of idle flags gives one request per 8 enabled cycles.
- R3: `tx_bit` changes only at a clock edge where `bit_en` is high. Data and trailer octets are sent LSB first.
- R4: After five consecutive ones in data or trailer, a 0 is inserted. The run is counted across octet boundaries, and a run that ends just before the closing flag is also stuffed.
- R5: Every frame is preceded by a full flag. The last trailer octet is followed by a closing flag, and the line then returns to idle flags.
- R6: With `cfg_crc32` low, the trailer is two octets. It is the complement of the CRC-16 (x^16+x^12+x^5+1, preset all ones, reflected), low octet first. For payload "123456789" the octets are 0x6E, 0x90.
- R7: With `cfg_crc32` high, the trailer is four octets. It is the complemented reflected CRC-32 (Ethernet polynomial, preset all ones), low octet first. For "123456789" the octets are 0x26, 0x39, 0xF4, 0xCB.
- R8: If a byte request sees `msg_en` low and `fcs_cmd` low in DATA, the frame is closed with a flag and no trailer.
- R9: With `cfg_enable` low, `tx_bit` is 1 and `byte_req` is 0, and no byte is consumed. When it is raised again, transmission restarts with a full flag.
- R10: With `cfg_loopback` high, `lb_bit` equals `tx_bit`. With it low, `lb_bit` is 1.
- R11: After reset, `tx_bit` is 1, and the first emitted octet is a flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_enable | input | 1 | Global HDLC enable |
| cfg_crc32 | input | 1 | 1 selects CRC-32 trailer, 0 selects CRC-16 |
| cfg_loopback | input | 1 | Drives the line bit onto `lb_bit` |
| bit_en | input | 1 | Emit one line bit this cycle |
| msg_en | input | 1 | Message pending; sampled on `byte_req` |
| fcs_cmd | input | 1 | Append trailer; sampled on `byte_req` |
| tx_data | input | 8 | Payload byte; sampled on `byte_req` |
| byte_req | output | 1 | Byte-request strobe |
| tx_bit | output | 1 | Serial line bit |
| lb_bit | output | 1 | Loopback tap |

## Verification
The bench decodes the line stream independently, removing stuffed zeros and splitting frames on flags, then compares the payload and the trailer against known CRC check values. A design that computed the CRC MSB first, or dropped the preset, would produce wrong trailer octets. A design that stuffed inside flags, or skipped the stuff before a closing flag, would corrupt the decoded frame. The stuffing case drives payload 0xFF 0xFF 0x7E 0xF8, so that runs of ones cross octet boundaries and end at the closing flag. Pacing `bit_en` on alternate cycles exposes designs that advance without a bit enable or request bytes off-beat. A disabled interval with a message pending exposes a design that would swallow bytes while off.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_DATA, ST_FCS} tx_state_e;

    localparam logic [7:0]  FLAG_OCTET = 8'h7E;
    localparam int          CRC_MAX_W  = 32;
    localparam logic [CRC_MAX_W-1:0] POLY16_REFL = 32'h0000_8408;
    localparam logic [CRC_MAX_W-1:0] POLY32_REFL = 32'hEDB8_8320;
    localparam int          STUFF_RUN  = 5;
    localparam int          OCTET_W    = 8;
    localparam int          BITCNT_W   = $clog2(OCTET_W);
endpackage

// File: rtl/hdlc_crc_unit.sv
module hdlc_crc_unit
    import hdlc_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 wide,
    input  logic                 bit_vld,
    input  logic                 bit_in,
    output logic [CRC_MAX_W-1:0] crc_next
);
    logic [CRC_MAX_W-1:0] crc_q;
    logic [CRC_MAX_W-1:0] cur;
    logic                 fb;

    always_comb begin
        cur      = wide ? crc_q : {16'h0000, crc_q[15:0]};
        fb       = cur[0] ^ bit_in;
        crc_next = (cur >> 1) ^ (fb ? (wide ? POLY32_REFL : POLY16_REFL) : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       crc_q <= '1;
        else if (clr)     crc_q <= '1;
        else if (bit_vld) crc_q <= crc_next;
    end
endmodule

// File: rtl/hdlc_bit_shifter.sv
module hdlc_bit_shifter
    import hdlc_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               bit_en,
    input  logic [OCTET_W-1:0] load_byte,
    input  logic               load_stuff,
    input  logic               load_crc,
    output logic               tx_bit,
    output logic               last_bit,
    output logic               crc_vld,
    output logic               crc_bit
);
    logic [OCTET_W-1:0]  sr;
    logic [BITCNT_W-1:0] bit_cnt;
    logic [2:0]          ones;
    logic                cur_stuff;
    logic                cur_crc;
    logic                stuff_now;
    logic                shift_now;

    always_comb begin
        stuff_now = (ones == 3'(STUFF_RUN));
        shift_now = bit_en && !clr && !stuff_now;
        last_bit  = shift_now && (bit_cnt == BITCNT_W'(OCTET_W - 1));
        crc_vld   = shift_now && cur_crc;
        crc_bit   = sr[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr        <= FLAG_OCTET;
            bit_cnt   <= '0;
            ones      <= '0;
            cur_stuff <= 1'b0;
            cur_crc   <= 1'b0;
            tx_bit    <= 1'b1;
        end else if (clr) begin
            sr        <= FLAG_OCTET;
            bit_cnt   <= '0;
            ones      <= '0;
            cur_stuff <= 1'b0;
            cur_crc   <= 1'b0;
            tx_bit    <= 1'b1;
        end else if (bit_en) begin
            if (stuff_now) begin
                tx_bit <= 1'b0;
                ones   <= '0;
            end else begin
                tx_bit  <= sr[0];
                ones    <= (cur_stuff && sr[0]) ? ones + 3'd1 : 3'd0;
                bit_cnt <= bit_cnt + 1'b1;
                if (last_bit) begin
                    sr        <= load_byte;
                    cur_stuff <= load_stuff;
                    cur_crc   <= load_crc;
                end else begin
                    sr <= {1'b0, sr[OCTET_W-1:1]};
                end
            end
        end
    end
endmodule

// File: rtl/hdlc_tx_ctrl.sv
module hdlc_tx_ctrl
    import hdlc_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 clr,
    input  logic                 take,
    input  logic                 msg_en,
    input  logic                 fcs_cmd,
    input  logic                 crc32,
    input  logic [OCTET_W-1:0]   tx_data,
    input  logic [CRC_MAX_W-1:0] crc_next,
    output logic [OCTET_W-1:0]   load_byte,
    output logic                 load_stuff,
    output logic                 load_crc,
    output logic                 crc_clr
);
    tx_state_e                    state, nxt;
    logic [CRC_MAX_W-OCTET_W-1:0] fcs_hold, hold_nxt;
    logic [1:0]                   fcs_left, left_nxt;
    logic [CRC_MAX_W-1:0]         fcs_word;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fcs_hold <= '0;
            fcs_left <= '0;
        end else if (clr) begin
            state    <= ST_IDLE;
            fcs_hold <= '0;
            fcs_left <= '0;
        end else if (take) begin
            state    <= nxt;
            fcs_hold <= hold_nxt;
            fcs_left <= left_nxt;
        end
    end

    // next state and octet selection
    always_comb begin
        fcs_word   = ~crc_next;
        nxt        = state;
        hold_nxt   = fcs_hold;
        left_nxt   = fcs_left;
        load_byte  = FLAG_OCTET;
        load_stuff = 1'b0;
        load_crc   = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (msg_en && !fcs_cmd) begin
                    load_byte  = tx_data;
                    load_stuff = 1'b1;
                    load_crc   = 1'b1;
                    nxt        = ST_DATA;
                end
            end
            ST_DATA: begin
                if (fcs_cmd) begin
                    load_byte  = fcs_word[OCTET_W-1:0];
                    load_stuff = 1'b1;
                    hold_nxt   = fcs_word[CRC_MAX_W-1:OCTET_W];
                    left_nxt   = crc32 ? 2'd3 : 2'd1;
                    nxt        = ST_FCS;
                end else if (msg_en) begin
                    load_byte  = tx_data;
                    load_stuff = 1'b1;
                    load_crc   = 1'b1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_FCS: begin
                if (fcs_left != 2'd0) begin
                    load_byte  = fcs_hold[OCTET_W-1:0];
                    load_stuff = 1'b1;
                    hold_nxt   = fcs_hold >> OCTET_W;
                    left_nxt   = fcs_left - 2'd1;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            default: nxt = ST_IDLE;
        endcase
        crc_clr = take && (nxt == ST_IDLE);
    end
endmodule

// File: rtl/hdlc_tx_serializer.sv
module hdlc_tx_serializer
    import hdlc_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_enable,
    input  logic       cfg_crc32,
    input  logic       cfg_loopback,
    input  logic       bit_en,
    input  logic       msg_en,
    input  logic       fcs_cmd,
    input  logic [7:0] tx_data,
    output logic       byte_req,
    output logic       tx_bit,
    output logic       lb_bit
);
    logic                 off;
    logic                 last_bit;
    logic                 crc_vld;
    logic                 crc_bit;
    logic                 crc_clr;
    logic [CRC_MAX_W-1:0] crc_next;
    logic [OCTET_W-1:0]   load_byte;
    logic                 load_stuff;
    logic                 load_crc;

    assign off      = !cfg_enable;
    assign byte_req = last_bit;
    assign lb_bit   = cfg_loopback ? tx_bit : 1'b1;

    hdlc_bit_shifter u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (off),
        .bit_en     (bit_en),
        .load_byte  (load_byte),
        .load_stuff (load_stuff),
        .load_crc   (load_crc),
        .tx_bit     (tx_bit),
        .last_bit   (last_bit),
        .crc_vld    (crc_vld),
        .crc_bit    (crc_bit)
    );

    hdlc_tx_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr        (off),
        .take       (last_bit),
        .msg_en     (msg_en),
        .fcs_cmd    (fcs_cmd),
        .crc32      (cfg_crc32),
        .tx_data    (tx_data),
        .crc_next   (crc_next),
        .load_byte  (load_byte),
        .load_stuff (load_stuff),
        .load_crc   (load_crc),
        .crc_clr    (crc_clr)
    );

    hdlc_crc_unit u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (crc_clr || off),
        .wide     (cfg_crc32),
        .bit_vld  (crc_vld),
        .bit_in   (crc_bit),
        .crc_next (crc_next)
    );
endmodule

// File: rtl/hdlc_tx_checker.sv
module hdlc_tx_checker (
    input logic clk,
    input logic rst_n,
    input logic cfg_enable,
    input logic bit_en,
    input logic byte_req,
    input logic tx_bit
);
    logic       ben_q;
    logic [2:0] run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ben_q <= 1'b0;
            run   <= '0;
        end else begin
            ben_q <= bit_en && cfg_enable;
            if (!cfg_enable)  run <= '0;
            else if (ben_q)   run <= tx_bit ? ((run == 3'd7) ? 3'd7 : run + 3'd1) : 3'd0;
        end
    end

    // R2
    req_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |-> (bit_en && cfg_enable));
    // R2
    req_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_req |=> !byte_req);
    // R3
    hold_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_en && cfg_enable) |=> $stable(tx_bit));
    // R9
    off_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_enable |=> tx_bit);
    // R4
    run_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_enable |-> (run <= 3'd6));
endmodule

bind hdlc_tx_serializer hdlc_tx_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_enable (cfg_enable),
    .bit_en     (bit_en),
    .byte_req   (byte_req),
    .tx_bit     (tx_bit)
);

// File: tb/sim_hdlc_tx_serializer.sv
module sim_hdlc_tx_serializer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_enable = 1'b1;
    logic       cfg_crc32 = 1'b0;
    logic       cfg_loopback = 1'b0;
    logic       bit_en = 1'b0;
    logic       msg_en = 1'b0;
    logic       fcs_cmd = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic       byte_req, tx_bit, lb_bit;

    always #2 clk = ~clk;

    hdlc_tx_serializer u0 (
        .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .cfg_crc32(cfg_crc32),
        .cfg_loopback(cfg_loopback), .bit_en(bit_en), .msg_en(msg_en), .fcs_cmd(fcs_cmd),
        .tx_data(tx_data), .byte_req(byte_req), .tx_bit(tx_bit), .lb_bit(lb_bit)
    );

    int tests = 0, fails = 0;
    logic [7:0] pay [0:15];
    int pay_n, fcs_n, idx, req_cnt, hold_err, req_err, lb_err, off_err;
    bit req_pend, prev_ben, prev_tx, gap_mode;
    bit sbits [0:8191];
    int scount;
    bit fb [0:1023];
    logic [7:0] dec [0:31];
    int dec_n, fr_n, bad_n, stuff_n;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        int rel;
        @(negedge clk);
        if (prev_ben && scount < 8192) begin sbits[scount] = tx_bit; scount++; end
        if (!prev_ben && tx_bit !== prev_tx && cfg_enable) hold_err++;
        if (req_pend) idx++;
        rel = idx - 2;
        if (rel >= 0 && rel < pay_n) begin
            msg_en = 1'b1; fcs_cmd = 1'b0; tx_data = pay[rel];
        end else if (rel >= pay_n && rel < pay_n + fcs_n) begin
            msg_en = 1'b1; fcs_cmd = 1'b1; tx_data = 8'h00;
        end else begin
            msg_en = 1'b0; fcs_cmd = 1'b0; tx_data = 8'h00;
        end
        bit_en = gap_mode ? ~bit_en : 1'b1;
        #1;
        req_pend = byte_req;
        if (byte_req) req_cnt++;
        if (byte_req && !bit_en) req_err++;
        if (cfg_loopback ? (lb_bit !== tx_bit) : (lb_bit !== 1'b1)) lb_err++;
        if (!cfg_enable && (tx_bit !== 1'b1 || byte_req)) off_err++;
        prev_ben = bit_en;
        prev_tx  = tx_bit;
    endtask

    task automatic start(input int np, input int nf);
        pay_n = np; fcs_n = nf; idx = 0; req_pend = 0; scount = 0; req_cnt = 0;
        hold_err = 0; req_err = 0; lb_err = 0; off_err = 0;
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic decode();
        int ones, cur;
        bit synced;
        ones = 0; cur = 0; synced = 0; dec_n = 0; fr_n = 0; bad_n = 0; stuff_n = 0;
        for (int i = 0; i < scount; i++) begin
            if (sbits[i]) begin
                ones++;
                if (cur < 1024) begin fb[cur] = 1'b1; cur++; end
            end else if (ones == 5) begin
                ones = 0;
                if (synced) stuff_n++;
            end else if (ones == 6) begin
                cur = (cur >= 7) ? cur - 7 : 0;
                if (synced && cur > 0) begin
                    if (cur % 8 == 0 && cur <= 256) begin
                        dec_n = cur / 8;
                        for (int k = 0; k < dec_n; k++)
                            for (int j = 0; j < 8; j++) dec[k][j] = fb[8*k+j];
                        fr_n++;
                    end else bad_n++;
                end
                cur = 0; synced = 1; ones = 0;
            end else begin
                if (cur < 1024) begin fb[cur] = 1'b0; cur++; end
                ones = 0;
            end
        end
    endtask

    task automatic load_check_string();
        for (int i = 0; i < 9; i++) pay[i] = 8'h31 + 8'(i);
    endtask

    function automatic int pay_mismatch();
        int m = 0;
        for (int i = 0; i < pay_n; i++) if (dec[i] !== pay[i]) m++;
        return m;
    endfunction

    task automatic t_reset_idle();
        check(tx_bit === 1'b1, "R11 reset line level", tx_bit, 1);
        check(byte_req === 1'b0, "R11 reset no request", byte_req, 0);
        gap_mode = 0; start(0, 0);
        run(65);
        begin
            int bad;
            logic [7:0] fl;
            bad = 0; fl = 8'h7E;
            for (int i = 0; i < 8; i++) if (sbits[i] !== fl[i]) bad++;
            check(bad == 0, "R11 first octet is flag", bad, 0);
            bad = 0;
            for (int i = 0; i < scount; i++) if (sbits[i] !== fl[i % 8]) bad++;
            check(bad == 0 && scount == 64, "R1 idle flag stream", bad, 0);
        end
        check(req_cnt == 8, "R2 one request per idle octet", req_cnt, 8);
    endtask

    task automatic t_crc16();
        load_check_string();
        cfg_crc32 = 0; gap_mode = 0; start(9, 2);
        run(300);
        decode();
        check(fr_n == 1 && bad_n == 0, "R5 single delimited frame", fr_n, 1);
        check(dec_n == 11, "R6 frame length with 2 trailer octets", dec_n, 11);
        check(pay_mismatch() == 0, "R3 payload LSB-first", pay_mismatch(), 0);
        check(dec[9] == 8'h6E && dec[10] == 8'h90, "R6 CRC-16 trailer",
              {dec[10], dec[9]}, 16'h906E);
        begin
            int bad;
            logic [7:0] fl;
            bad = 0; fl = 8'h7E;
            for (int i = scount - 16; i < scount; i++) if (sbits[i] == 1'b0) bad++;
            check(bad == 4, "R5 line back to flags after frame", bad, 4);
        end
    endtask

    task automatic t_crc32_paced();
        load_check_string();
        cfg_crc32 = 1; gap_mode = 1; start(9, 4);
        run(700);
        decode();
        check(fr_n == 1 && dec_n == 13, "R7 frame length with 4 trailer octets", dec_n, 13);
        check(pay_mismatch() == 0, "R7 payload under paced bits", pay_mismatch(), 0);
        check({dec[12], dec[11], dec[10], dec[9]} == 32'hCBF43926, "R7 CRC-32 trailer",
              {dec[12], dec[11], dec[10], dec[9]}, 32'hCBF43926);
        check(hold_err == 0, "R3 line holds without bit enable", hold_err, 0);
        check(req_err == 0, "R2 request only with bit enable", req_err, 0);
        cfg_crc32 = 0; gap_mode = 0;
    endtask

    task automatic t_stuff_abandon();
        pay[0] = 8'hFF; pay[1] = 8'hFF; pay[2] = 8'h7E; pay[3] = 8'hF8;
        gap_mode = 0; start(4, 0);
        run(200);
        decode();
        check(stuff_n >= 3, "R4 zeros inserted", stuff_n, 3);
        check(fr_n == 1 && bad_n == 0 && dec_n == 4, "R8 closed without trailer", dec_n, 4);
        check(pay_mismatch() == 0, "R4 stuffed payload recovered", pay_mismatch(), 0);
    endtask

    task automatic t_disable();
        pay[0] = 8'hA5; pay[1] = 8'h3C;
        cfg_enable = 0; gap_mode = 0; start(2, 0);
        run(100);
        check(off_err == 0, "R9 line high while off", off_err, 0);
        check(req_cnt == 0 && idx == 0, "R9 no request while off", req_cnt, 0);
        cfg_enable = 1; scount = 0;
        run(120);
        begin
            int bad;
            logic [7:0] fl;
            bad = 0; fl = 8'h7E;
            for (int i = 0; i < 8; i++) if (sbits[i] !== fl[i]) bad++;
            check(bad == 0, "R9 restart with flag", bad, 0);
        end
        decode();
        check(fr_n == 1 && dec_n == 2 && pay_mismatch() == 0, "R9 no byte lost while off",
              dec_n, 2);
    endtask

    task automatic t_loopback();
        gap_mode = 0; start(0, 0);
        cfg_loopback = 1; run(40);
        check(lb_err == 0, "R10 tap follows line", lb_err, 0);
        lb_err = 0; cfg_loopback = 0; run(40);
        check(lb_err == 0, "R10 tap idle high", lb_err, 0);
    endtask

    initial begin
        #(4 * 200000);
        tests++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        pay_n = 0; fcs_n = 0; idx = 0; prev_ben = 0; prev_tx = 1; gap_mode = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        t_reset_idle();
        t_crc16();
        t_crc32_paced();
        t_stuff_abandon();
        t_disable();
        t_loopback();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule